// File: doc/BRIEF.md
# ADC Result Store with Window and Crossing Classification

This block sits behind a 12-bit analog-to-digital converter and post-processes every completed conversion. Each conversion arrives as a one-cycle strobe that carries a channel number and a sample. The block keeps the newest sample of every channel together with two classification codes. The range code places the sample against a low and high bound. The crossing code says whether the sample moved across the low bound since the previous sample on the same channel. Each channel chooses one of two shared bound pairs (set A or set B) with its own select bit.

Each channel holds a valid bit that a new result sets and a read clears. It also holds a sticky overrun bit that is raised when a result replaces one that was never read. All overrun bits are gathered into a flags word. Software-side logic reads the channel words and the flags word through a simple registered read port.

The crossing history of each channel is a three-state machine. `HS_EMPTY` is entered from reset and whenever the channel is disabled. `HS_BELOW` is entered when an accepted sample is lower than the selected low bound. `HS_ABOVE` is entered when an accepted sample is equal to or greater than that bound. The transitions are: EMPTY to BELOW or ABOVE on the first accepted result; BELOW to ABOVE on an upward crossing; ABOVE to BELOW on a downward crossing; a self-loop when the side does not change; any state to EMPTY while the channel enable is low.

Top module: `adc_thresh_result`

## Requirements
- R1: A `conv_done` strobe on an enabled channel c (c below 12) with sample s is visible one clock later in channel c's word. The word holds s at bits 15:4, bit 31 (valid) is 1, and other channels are unchanged.
- R2: The range code at bits 17:16 is 1 when s is below the low bound. Otherwise it is 2 when s is above the high bound, and 0 otherwise, with both bounds inclusive. The bounds come from set B when `thr_sel[c]` is 1 and from set A when it is 0, taken at the strobe. When the low bound exceeds the high bound, code 1 has priority.
- R3: The range code never takes the value 3.
- R4: The crossing code at bits 19:18 is 3 (up) when the previous sample was below the low bound and the current one is not. It is 2 (down) in the opposite case and 0 when the side is unchanged. A sample equal to the low bound counts as above. Code 1 never appears.
- R5: The first accepted result after reset, or after the channel enable was low, reports crossing code 0.
- R6: Overrun (bit 30) is set when a result is written into a channel whose valid bit is 1 and is not being read in the same cycle. It stays set until a read.
- R7: With `rd_en` high and `rd_addr` = c < 12, `rd_data` shows channel c's word one clock later, and valid and overrun of channel c are cleared. If a result for c arrives in that same cycle, the read returns the old word and the new result is stored with valid 1 and overrun 0.
- R8: Reading address 12 returns the flags word, with bit c equal to channel c's overrun. `ovr_flags` shows the same bits continuously. Addresses 13 to 15 read zero.
- R9: While `chan_en[c]` is 0, strobes for channel c leave its word unchanged.
- R10: Bits 3:0 and 29:20 of every channel word read zero.
- R11: After reset every channel word and the flags word are zero.
- R12: A strobe whose channel number is 12 or above changes no channel word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| conv_chan | input | 4 | Channel number of the completed conversion |
| conv_data | input | 12 | Converted sample |
| chan_en | input | 12 | Per-channel enable; low drops results and clears history |
| thr_sel | input | 12 | Per-channel bound set select (0 = set A, 1 = set B) |
| thr_lo_a | input | 12 | Set A low bound |
| thr_hi_a | input | 12 | Set A high bound |
| thr_lo_b | input | 12 | Set B low bound |
| thr_hi_b | input | 12 | Set B high bound |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address: 0-11 channel words, 12 flags word |
| rd_data | output | 32 | Registered read data, valid one clock after `rd_en` |
| ovr_flags | output | 12 | Live overrun bits, one per channel |

## Verification
A strobe presented before a rising edge lands in the channel word at that edge. A read requested before the following edge returns the word one edge later, so every result is observed two edges after its strobe. The bench drives all inputs just after a falling edge and samples `rd_data` at the next falling edge. This keeps each observation half a period away from the edge that produced it. The same-cycle read-and-write case is driven in one cycle. Its old word is checked on the next falling edge, and the new word is checked by a separate later read.

// File: rtl/adcth_pkg.sv
package adcth_pkg;

    typedef enum logic [1:0] {
        RNG_IN    = 2'd0,
        RNG_BELOW = 2'd1,
        RNG_ABOVE = 2'd2
    } rng_e;

    typedef enum logic [1:0] {
        XC_NONE = 2'd0,
        XC_DOWN = 2'd2,
        XC_UP   = 2'd3
    } xc_e;

    typedef enum logic [1:0] {
        HS_EMPTY = 2'd0,
        HS_BELOW = 2'd1,
        HS_ABOVE = 2'd2
    } hist_e;

    localparam int WORD_W    = 32;
    localparam int RES_LSB   = 4;
    localparam int RNG_LSB   = 16;
    localparam int XC_LSB    = 18;
    localparam int OVR_BIT   = 30;
    localparam int VALID_BIT = 31;

endpackage

// File: rtl/adcth_window.sv
module adcth_window
    import adcth_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] sample,
    input  logic [RES_W-1:0] lo,
    input  logic [RES_W-1:0] hi,
    output rng_e             rng,
    output logic             at_or_above_lo
);

    logic below_lo;
    logic above_hi;

    always_comb begin
        below_lo       = (sample < lo);
        above_hi       = (sample > hi);
        at_or_above_lo = !below_lo;
        if (below_lo) begin
            rng = RNG_BELOW;
        end else if (above_hi) begin
            rng = RNG_ABOVE;
        end else begin
            rng = RNG_IN;
        end
    end

endmodule

// File: rtl/adcth_chan.sv
module adcth_chan
    import adcth_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr,
    input  logic             rd_clr,
    input  logic [RES_W-1:0] sample,
    input  logic [RES_W-1:0] lo,
    input  logic [RES_W-1:0] hi,
    output logic [RES_W-1:0] result_q,
    output rng_e             rng_q,
    output xc_e              xc_q,
    output logic             valid_q,
    output logic             ovr_q
);

    hist_e hist_q;
    hist_e hist_d;
    rng_e  rng_now;
    xc_e   xc_now;
    logic  side_hi;
    logic  accept;

    assign accept = wr && en;

    adcth_window #(.RES_W(RES_W)) u_window (
        .sample         (sample),
        .lo             (lo),
        .hi             (hi),
        .rng            (rng_now),
        .at_or_above_lo (side_hi)
    );

    // history state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= HS_EMPTY;
        end else begin
            hist_q <= hist_d;
        end
    end

    // next history state and crossing decision
    always_comb begin
        hist_d = hist_q;
        xc_now = XC_NONE;
        unique case (hist_q)
            HS_EMPTY: begin
                xc_now = XC_NONE;
            end
            HS_BELOW: begin
                xc_now = side_hi ? XC_UP : XC_NONE;
            end
            HS_ABOVE: begin
                xc_now = side_hi ? XC_NONE : XC_DOWN;
            end
            default: begin
                xc_now = XC_NONE;
            end
        endcase
        if (!en) begin
            hist_d = HS_EMPTY;
        end else if (wr) begin
            hist_d = side_hi ? HS_ABOVE : HS_BELOW;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            rng_q    <= RNG_IN;
            xc_q     <= XC_NONE;
            valid_q  <= 1'b0;
            ovr_q    <= 1'b0;
        end else if (accept) begin
            result_q <= sample;
            rng_q    <= rng_now;
            xc_q     <= xc_now;
            valid_q  <= 1'b1;
            ovr_q    <= !rd_clr && (ovr_q || valid_q);
        end else if (rd_clr) begin
            valid_q  <= 1'b0;
            ovr_q    <= 1'b0;
        end
    end

    AST_RNG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rng_q != 2'd3); // R3
    AST_XC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) xc_q != 2'd1); // R4
    AST_FIRST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n) (accept && hist_q == HS_EMPTY) |=> (xc_q == XC_NONE)); // R5
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (accept && valid_q && !rd_clr) |=> ovr_q); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovr_q && !rd_clr) |=> ovr_q); // R6
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_clr && !accept) |=> (!valid_q && !ovr_q)); // R7
    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(result_q)); // R9
    AST_DIS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (hist_q == HS_EMPTY)); // R5

endmodule

// File: rtl/adcth_readport.sv
module adcth_readport
    import adcth_pkg::*;
#(
    parameter int NCH = 12,
    parameter int AW  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [AW-1:0]                rd_addr,
    input  logic [NCH-1:0][WORD_W-1:0]   words,
    input  logic [NCH-1:0]               flags,
    output logic [WORD_W-1:0]            rd_data
);

    logic [WORD_W-1:0] sel_word;
    logic              was_chan_q;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(i)) begin
                sel_word = words[i];
            end
        end
        if (rd_addr == AW'(NCH)) begin
            sel_word = WORD_W'(flags);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data    <= '0;
            was_chan_q <= 1'b0;
        end else if (rd_en) begin
            rd_data    <= sel_word;
            was_chan_q <= (rd_addr < AW'(NCH));
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) was_chan_q |-> (rd_data[3:0] == 4'd0 && rd_data[29:20] == 10'd0)); // R10

endmodule

// File: rtl/adc_thresh_result.sv
module adc_thresh_result
    import adcth_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int RES_W = 12,
    localparam int AW   = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [AW-1:0]     conv_chan,
    input  logic [RES_W-1:0]  conv_data,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH-1:0]    thr_sel,
    input  logic [RES_W-1:0]  thr_lo_a,
    input  logic [RES_W-1:0]  thr_hi_a,
    input  logic [RES_W-1:0]  thr_lo_b,
    input  logic [RES_W-1:0]  thr_hi_b,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [31:0]       rd_data,
    output logic [NCH-1:0]    ovr_flags
);

    logic [NCH-1:0][WORD_W-1:0] words;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [RES_W-1:0] res_c;
        rng_e             rng_c;
        xc_e              xc_c;
        logic             val_c;
        logic             ovr_c;
        logic             wr_c;
        logic             clr_c;
        logic [RES_W-1:0] lo_c;
        logic [RES_W-1:0] hi_c;

        assign wr_c  = conv_done && (conv_chan == AW'(c));
        assign clr_c = rd_en && (rd_addr == AW'(c));
        assign lo_c  = thr_sel[c] ? thr_lo_b : thr_lo_a;
        assign hi_c  = thr_sel[c] ? thr_hi_b : thr_hi_a;

        adcth_chan #(.RES_W(RES_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (chan_en[c]),
            .wr       (wr_c),
            .rd_clr   (clr_c),
            .sample   (conv_data),
            .lo       (lo_c),
            .hi       (hi_c),
            .result_q (res_c),
            .rng_q    (rng_c),
            .xc_q     (xc_c),
            .valid_q  (val_c),
            .ovr_q    (ovr_c)
        );

        always_comb begin
            words[c]                    = '0;
            words[c][RES_LSB +: RES_W]  = res_c;
            words[c][RNG_LSB +: 2]      = rng_c;
            words[c][XC_LSB +: 2]       = xc_c;
            words[c][OVR_BIT]           = ovr_c;
            words[c][VALID_BIT]         = val_c;
        end

        assign ovr_flags[c] = ovr_c;
    end

    adcth_readport #(.NCH(NCH), .AW(AW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .words   (words),
        .flags   (ovr_flags),
        .rd_data (rd_data)
    );

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (conv_done && conv_chan >= AW'(NCH) && !rd_en) |=> $stable(words)); // R12
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (conv_done && conv_chan < AW'(NCH) && chan_en[conv_chan]) |=> (words[$past(conv_chan)][VALID_BIT] && words[$past(conv_chan)][RES_LSB +: RES_W] == $past(conv_data))); // R1

endmodule

// File: tb/adc_thresh_result_bench.sv
module adc_thresh_result_bench;

    localparam int NCH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [3:0]  conv_chan = '0;
    logic [11:0] conv_data = '0;
    logic [11:0] chan_en = '0;
    logic [11:0] thr_sel = '0;
    logic [11:0] thr_lo_a = '0, thr_hi_a = '0, thr_lo_b = '0, thr_hi_b = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [11:0] ovr_flags;

    int errors = 0;
    int checks = 0;

    int m_res [NCH];
    int m_rng [NCH];
    int m_xc  [NCH];
    int m_hist[NCH];
    bit m_val [NCH];
    bit m_ovr [NCH];

    always #10 clk = ~clk;

    adc_thresh_result u_adc_thresh_result (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_chan(conv_chan),
        .conv_data(conv_data), .chan_en(chan_en), .thr_sel(thr_sel),
        .thr_lo_a(thr_lo_a), .thr_hi_a(thr_hi_a), .thr_lo_b(thr_lo_b), .thr_hi_b(thr_hi_b),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ovr_flags(ovr_flags)
    );

    function automatic logic [31:0] exp_word(int ch);
        logic [31:0] w;
        w = '0;
        w[15:4]  = 12'(m_res[ch]);
        w[17:16] = 2'(m_rng[ch]);
        w[19:18] = 2'(m_xc[ch]);
        w[30]    = m_ovr[ch];
        w[31]    = m_val[ch];
        return w;
    endfunction

    function automatic logic [11:0] exp_flags();
        logic [11:0] f;
        for (int i = 0; i < NCH; i++) f[i] = m_ovr[i];
        return f;
    endfunction

    task automatic check32(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // model update for an accepted strobe; rd_same means a read of ch in that cycle
    task automatic model_conv(int ch, int s, bit rd_same);
        int lo, hi, side;
        if (ch >= NCH || !chan_en[ch]) return;
        lo = thr_sel[ch] ? int'(thr_lo_b) : int'(thr_lo_a);
        hi = thr_sel[ch] ? int'(thr_hi_b) : int'(thr_hi_a);
        side = (s >= lo) ? 2 : 1;
        m_rng[ch] = (s < lo) ? 1 : ((s > hi) ? 2 : 0);
        if (m_hist[ch] == 1 && side == 2)      m_xc[ch] = 3;
        else if (m_hist[ch] == 2 && side == 1) m_xc[ch] = 2;
        else                                   m_xc[ch] = 0;
        m_hist[ch] = side;
        m_ovr[ch]  = !rd_same && (m_ovr[ch] || m_val[ch]);
        m_val[ch]  = 1'b1;
        m_res[ch]  = s;
    endtask

    task automatic convert(int ch, int s);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = 4'(ch); conv_data = 12'(s);
        @(negedge clk);
        conv_done = 1'b0;
        model_conv(ch, s, 1'b0);
    endtask

    task automatic read_chk(int addr, string tag);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'(addr);
        if (addr < NCH)       exp = exp_word(addr);
        else if (addr == NCH) exp = {20'd0, exp_flags()};
        else                  exp = '0;
        @(negedge clk);
        rd_en = 1'b0;
        check32(tag, rd_data, exp);
        if (addr < NCH) begin
            m_val[addr] = 1'b0;
            m_ovr[addr] = 1'b0;
        end
    endtask

    task automatic set_enable(int ch, bit v);
        @(negedge clk);
        chan_en[ch] = v;
        if (!v) m_hist[ch] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_res[i] = 0; m_rng[i] = 0; m_xc[i] = 0; m_hist[i] = 0; m_val[i] = 0; m_ovr[i] = 0;
        end
        thr_lo_a = 12'h400; thr_hi_a = 12'hC00;
        thr_lo_b = 12'h100; thr_hi_b = 12'h200;
        thr_sel  = 12'hAAA;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        for (int ch = 0; ch <= NCH; ch++) read_chk(ch, "R11 reset word");
        checks++;
        if (ovr_flags !== 12'd0) begin
            errors++; $display("FAIL R11 flags: got %h expected 000", ovr_flags);
        end

        @(negedge clk); chan_en = 12'hFFF;

        // R1 R2 R4 R5 R10: boundary sweep on every channel, set chosen by thr_sel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < 9; k++) begin
                int lo, hi, s;
                lo = thr_sel[ch] ? int'(thr_lo_b) : int'(thr_lo_a);
                hi = thr_sel[ch] ? int'(thr_hi_b) : int'(thr_hi_a);
                case (k)
                    0: s = lo - 1;
                    1: s = lo;
                    2: s = lo + 1;
                    3: s = hi;
                    4: s = hi + 1;
                    5: s = 0;
                    6: s = 4095;
                    7: s = lo;
                    default: s = lo - 1;
                endcase
                convert(ch, s);
                read_chk(ch, "R1 R2 R4 R10 sweep");
            end
        end

        // R2: select change and inverted bounds (low above high)
        @(negedge clk); thr_sel[0] = 1'b1; thr_lo_b = 12'h800; thr_hi_b = 12'h100;
        convert(0, 12'h500); read_chk(0, "R2 inverted bounds below");
        convert(0, 12'h900); read_chk(0, "R2 inverted bounds above");
        convert(0, 12'h050); read_chk(0, "R2 R4 inverted bounds down");
        @(negedge clk); thr_lo_b = 12'h100; thr_hi_b = 12'h200;

        // R6 R8: overrun on two channels, flags word and live flags
        convert(2, 12'h111); convert(2, 12'h222);
        convert(5, 12'h333); convert(5, 12'h444); convert(5, 12'h555);
        @(negedge clk);
        checks++;
        if (ovr_flags !== exp_flags()) begin
            errors++; $display("FAIL R8 live flags: got %h expected %h", ovr_flags, exp_flags());
        end
        read_chk(NCH, "R8 flags word");
        read_chk(13, "R8 unused address");
        read_chk(15, "R8 unused address top");
        read_chk(2, "R6 overrun word");
        read_chk(2, "R7 cleared after read");
        read_chk(5, "R6 overrun word");
        read_chk(NCH, "R8 flags cleared");

        // R9 R5: disabled channel ignores strobes, first result after enable has no crossing
        set_enable(7, 1'b0);
        convert(7, 12'hABC);
        read_chk(7, "R9 disabled word unchanged");
        set_enable(7, 1'b1);
        convert(7, 12'hFFF);
        read_chk(7, "R5 first after enable");
        convert(7, 12'h000);
        read_chk(7, "R4 down after enable");

        // R12: out-of-range channel numbers
        convert(12, 12'h777); convert(15, 12'h0F0);
        for (int ch = 0; ch < NCH; ch++) read_chk(ch, "R12 no change");

        // R7: read and write to the same channel in one cycle
        convert(3, 12'h010);
        @(negedge clk);
        begin
            logic [31:0] old_w;
            old_w = exp_word(3);
            rd_en = 1'b1; rd_addr = 4'd3;
            conv_done = 1'b1; conv_chan = 4'd3; conv_data = 12'h3FF;
            @(negedge clk);
            rd_en = 1'b0; conv_done = 1'b0;
            check32("R7 collision old word", rd_data, old_w);
            model_conv(3, 12'h3FF, 1'b1);
        end
        read_chk(3, "R7 collision new word");
        read_chk(3, "R7 collision cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule